// File: doc/BRIEF.md
# Debug Command Stream Sequencer

This block is the target-side engine for a byte-serial debug and programming command stream. Command bytes arrive on a valid/ready input. Each opcode selects one of eight instruction classes: direct load, direct store, pointer load, pointer store, control-register load, control-register store, repeat and key. The sequencer collects the address and data operand bytes that follow the opcode. It keeps a 32-bit internal pointer and issues single memory accesses of one to four bytes on a simple request/ready memory bus. Load results go back, least-significant byte first, on a valid/ready output byte stream.

Control-register reads and writes, and the 64-bit key, are handed to a separate register block over a narrow port. Direct accesses leave their address in the pointer, so later pointer-mode instructions depend on the order of instructions. A repeat instruction runs the following instruction again a given number of times without its opcode being resent. An abort input returns the engine to opcode fetch at any time.

Top module: `dbg_seq`

## Requirements
- R1: While and directly after reset the block is quiet and waits for an opcode: in_ready is 1, and out_valid, mem_we, mem_re, reg_wr, reg_rd and key_valid are 0. The pointer and the repeat count reset to 0.
- R2: Opcode bits [7:5] select the class: 000 direct load, 001 pointer load, 010 direct store, 011 pointer store, 100 register load, 101 repeat, 110 register store, 111 key. Bits [3:2] hold the address size or the pointer mode, and bits [1:0] hold the data size. Bit 4 has no effect. At most one of a memory request, reg_wr, reg_rd or key_valid is active in a cycle.
- R3: A size field value s (2 bits) means s+1 operand bytes. Every multi-byte operand and every returned value is least-significant byte first. Operands shorter than the field they fill are zero-extended, and unused upper write-data bytes are 0. An output byte is held stable while out_valid is 1 and out_ready is 0.
- R4: A direct load takes A+1 address bytes. It then issues one read with mem_addr set to the zero-extended address and mem_size set to B, and returns B+1 bytes of mem_rdata.
- R5: A direct store takes A+1 address bytes, then B+1 data bytes. It issues one write to that address with mem_size B and mem_wdata holding the data bytes, first byte in bits [7:0].
- R6: A direct load or store copies its zero-extended address into the pointer.
- R7: Pointer mode 00 reads or writes at the pointer address with size B. Mode 01 does the same and then adds B+1 to the pointer.
- R8: Pointer mode 10 on a store loads B+1 data bytes, zero-extended, into the pointer. On a load it returns the low B+1 bytes of the pointer.
- R9: Pointer mode 11 is a no-op. It consumes no operand bytes, makes no memory access, produces no output and leaves the pointer unchanged.
- R10: A register store takes one data byte and pulses reg_wr for one cycle, with reg_sel equal to opcode bits [3:0]. A register load pulses reg_rd with that select, samples reg_rdata in the same cycle, and returns it as one output byte.
- R11: A repeat instruction takes B+1 count bytes, zero-padded to 32 bits. The next instruction then runs once plus count more times. Repeated runs take their operand bytes from the stream again but no opcode. Later instructions run once.
- R12: A key instruction takes exactly 8 bytes and pulses key_valid for one cycle, with key_value holding the 64-bit value, first byte in bits [7:0].
- R13: An abort returns the block to opcode fetch with in_ready 1. It clears the repeat count and drops any memory request and pending output bytes. The pointer keeps its value.
- R14: A memory request (mem_we or mem_re) and its address, size and write data stay stable until mem_ready is seen. mem_we and mem_re are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Abandon the current instruction |
| in_valid | input | 1 | Command byte available |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Sequencer accepts a command byte |
| out_valid | output | 1 | Result byte available |
| out_data | output | 8 | Result byte |
| out_ready | input | 1 | Consumer takes the result byte |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access length minus one, in bytes |
| mem_wdata | output | 8*DBYTES | Write data, first byte lowest |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdata | input | 8*DBYTES | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request |
| reg_sel | output | 4 | Control register index |
| reg_wdata | output | 8 | Control register write data |
| reg_wr | output | 1 | Control register write pulse |
| reg_rd | output | 1 | Control register read strobe |
| reg_rdata | input | 8 | Control register read data for reg_sel |
| key_valid | output | 1 | Key value presented, one-cycle pulse |
| key_value | output | 8*KEYB | Collected key value |

## Verification
The assertions assume that abort_i is raised only while no command byte is offered. They also assume that mem_rdata is valid whenever mem_ready is 1, and that reg_rdata follows reg_sel within the same cycle. The bench drives abort only between bytes, with in_valid low. Its memory and register models return data combinationally from the current address or select. It randomizes mem_ready and out_ready every cycle, so the hold properties on requests and output bytes are exercised under stalls. Nothing it drives breaks those premises.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    CLS_LD_DIR  = 3'b000,
    CLS_LD_PTR  = 3'b001,
    CLS_ST_DIR  = 3'b010,
    CLS_ST_PTR  = 3'b011,
    CLS_LD_REG  = 3'b100,
    CLS_REPEAT  = 3'b101,
    CLS_ST_REG  = 3'b110,
    CLS_KEY     = 3'b111
  } op_class_t;

  typedef enum logic [1:0] {
    PM_DEREF   = 2'b00,
    PM_POSTINC = 2'b01,
    PM_SELF    = 2'b10,
    PM_NONE    = 2'b11
  } ptr_mode_t;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_ADDR_DONE,
    ST_DATA,
    ST_DATA_DONE,
    ST_MEM,
    ST_REG_RD,
    ST_SEND
  } seq_state_t;

endpackage

// File: rtl/dbg_seq_gather.sv
module dbg_seq_gather #(
  parameter int NBYTES = 8,
  parameter int CW     = $clog2(NBYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  push,
  input  logic [7:0]            din,
  output logic [CW-1:0]         cnt,
  output logic [8*NBYTES-1:0]   value
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (push && (cnt < CW'(NBYTES))) begin
      cnt <= cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_slot
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        byte_q <= '0;
      end else if (push && (cnt == CW'(i))) begin
        byte_q <= din;
      end
    end
    assign value[8*i +: 8] = byte_q;
  end

endmodule

// File: rtl/dbg_seq_emit.sv
module dbg_seq_emit #(
  parameter int NBYTES = 4,
  parameter int NBW    = $clog2(NBYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  load,
  input  logic [8*NBYTES-1:0]   word,
  input  logic [NBW-1:0]        nbytes,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  input  logic                  out_ready,
  output logic                  busy
);

  logic [8*NBYTES-1:0] shift_q;
  logic [NBW-1:0]      left_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shift_q <= '0;
      left_q  <= '0;
    end else if (load) begin
      shift_q <= word;
      left_q  <= nbytes;
    end else if ((left_q != '0) && out_ready) begin
      shift_q <= shift_q >> 8;
      left_q  <= left_q - NBW'(1);
    end
  end

  assign out_valid = (left_q != '0);
  assign out_data  = shift_q[7:0];
  assign busy      = out_valid;

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq #(
  parameter int AW     = 32,
  parameter int DBYTES = 4,
  parameter int KEYB   = 8,
  parameter int CNTW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort_i,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  input  logic                 out_ready,
  output logic [AW-1:0]        mem_addr,
  output logic [1:0]           mem_size,
  output logic [8*DBYTES-1:0]  mem_wdata,
  output logic                 mem_we,
  output logic                 mem_re,
  input  logic [8*DBYTES-1:0]  mem_rdata,
  input  logic                 mem_ready,
  output logic [3:0]           reg_sel,
  output logic [7:0]           reg_wdata,
  output logic                 reg_wr,
  output logic                 reg_rd,
  input  logic [7:0]           reg_rdata,
  output logic                 key_valid,
  output logic [8*KEYB-1:0]    key_value
);
  import dbg_seq_pkg::*;

  localparam int DW  = 8 * DBYTES;
  localparam int KW  = 8 * KEYB;
  localparam int GCW = $clog2(KEYB + 1);
  localparam int NBW = $clog2(DBYTES + 1);

  seq_state_t      st;
  op_class_t       cls_q;
  logic [3:0]      lo_q;
  logic [AW-1:0]   ptr_q;
  logic [CNTW-1:0] rpt_q;
  logic [GCW-1:0]  need_q;

  logic [1:0]      fa, fb;
  ptr_mode_t       pmode;
  logic [NBW-1:0]  nb;
  assign fa    = lo_q[3:2];
  assign fb    = lo_q[1:0];
  assign pmode = ptr_mode_t'(lo_q[3:2]);
  assign nb    = NBW'(fb) + NBW'(1);

  // Operand collection
  logic            g_clr, g_push, g_last;
  logic [GCW-1:0]  g_cnt;
  logic [KW-1:0]   g_val;

  assign in_ready = (st == ST_FETCH) || (st == ST_ADDR) || (st == ST_DATA);
  assign g_push   = in_valid && !abort_i && ((st == ST_ADDR) || (st == ST_DATA));
  assign g_last   = g_push && (g_cnt == need_q - GCW'(1));
  assign g_clr    = abort_i || (st == ST_DECODE) || (st == ST_ADDR_DONE);

  dbg_seq_gather #(.NBYTES(KEYB), .CW(GCW)) u_gather (
    .clk   (clk),
    .rst   (rst),
    .clr   (g_clr),
    .push  (g_push),
    .din   (in_data),
    .cnt   (g_cnt),
    .value (g_val)
  );

  // Result serializer
  logic            e_load, e_busy;
  logic [DW-1:0]   e_word;
  logic [NBW-1:0]  e_nb;

  always_comb begin
    e_load = 1'b0;
    e_word = '0;
    e_nb   = nb;
    if (!abort_i) begin
      if (st == ST_DECODE && cls_q == CLS_LD_PTR && pmode == PM_SELF) begin
        e_load = 1'b1;
        e_word = ptr_q[DW-1:0];
      end else if (st == ST_MEM && mem_re && mem_ready) begin
        e_load = 1'b1;
        e_word = mem_rdata;
      end else if (st == ST_REG_RD) begin
        e_load = 1'b1;
        e_word = DW'(reg_rdata);
        e_nb   = NBW'(1);
      end
    end
  end

  dbg_seq_emit #(.NBYTES(DBYTES), .NBW(NBW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .clr       (abort_i),
    .load      (e_load),
    .word      (e_word),
    .nbytes    (e_nb),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .busy      (e_busy)
  );

  // End-of-instruction: replay while the repeat count is nonzero
  seq_state_t      fin_st;
  logic [CNTW-1:0] fin_rpt;
  assign fin_st  = (rpt_q != '0) ? ST_DECODE : ST_FETCH;
  assign fin_rpt = (rpt_q != '0) ? rpt_q - CNTW'(1) : rpt_q;

  logic ptr_post;
  assign ptr_post = ((cls_q == CLS_LD_PTR) || (cls_q == CLS_ST_PTR)) && (pmode == PM_POSTINC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FETCH;
      cls_q     <= CLS_LD_DIR;
      lo_q      <= '0;
      ptr_q     <= '0;
      rpt_q     <= '0;
      need_q    <= '0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      reg_sel   <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      key_valid <= 1'b0;
      key_value <= '0;
    end else begin
      reg_wr    <= 1'b0;
      key_valid <= 1'b0;
      if (abort_i) begin
        st     <= ST_FETCH;
        rpt_q  <= '0;
        mem_we <= 1'b0;
        mem_re <= 1'b0;
        reg_rd <= 1'b0;
      end else begin
        case (st)
          ST_FETCH: begin
            if (in_valid) begin
              cls_q <= op_class_t'(in_data[7:5]);
              lo_q  <= in_data[3:0];
              st    <= ST_DECODE;
            end
          end

          ST_DECODE: begin
            case (cls_q)
              CLS_LD_DIR, CLS_ST_DIR: begin
                need_q <= GCW'(fa) + GCW'(1);
                st     <= ST_ADDR;
              end
              CLS_LD_PTR: begin
                if (pmode == PM_NONE) begin
                  st    <= fin_st;
                  rpt_q <= fin_rpt;
                end else if (pmode == PM_SELF) begin
                  st <= ST_SEND;
                end else begin
                  mem_re   <= 1'b1;
                  mem_addr <= ptr_q;
                  mem_size <= fb;
                  st       <= ST_MEM;
                end
              end
              CLS_ST_PTR: begin
                if (pmode == PM_NONE) begin
                  st    <= fin_st;
                  rpt_q <= fin_rpt;
                end else begin
                  need_q <= GCW'(fb) + GCW'(1);
                  st     <= ST_DATA;
                end
              end
              CLS_LD_REG: begin
                reg_rd  <= 1'b1;
                reg_sel <= lo_q;
                st      <= ST_REG_RD;
              end
              CLS_ST_REG: begin
                need_q <= GCW'(1);
                st     <= ST_DATA;
              end
              CLS_REPEAT: begin
                need_q <= GCW'(fb) + GCW'(1);
                st     <= ST_DATA;
              end
              default: begin
                need_q <= GCW'(KEYB);
                st     <= ST_DATA;
              end
            endcase
          end

          ST_ADDR: begin
            if (g_last) st <= ST_ADDR_DONE;
          end

          ST_ADDR_DONE: begin
            ptr_q <= g_val[AW-1:0];
            if (cls_q == CLS_LD_DIR) begin
              mem_re   <= 1'b1;
              mem_addr <= g_val[AW-1:0];
              mem_size <= fb;
              st       <= ST_MEM;
            end else begin
              need_q <= GCW'(fb) + GCW'(1);
              st     <= ST_DATA;
            end
          end

          ST_DATA: begin
            if (g_last) st <= ST_DATA_DONE;
          end

          ST_DATA_DONE: begin
            case (cls_q)
              CLS_ST_DIR, CLS_ST_PTR: begin
                if (cls_q == CLS_ST_PTR && pmode == PM_SELF) begin
                  ptr_q <= g_val[AW-1:0];
                  st    <= fin_st;
                  rpt_q <= fin_rpt;
                end else begin
                  mem_we    <= 1'b1;
                  mem_addr  <= ptr_q;
                  mem_size  <= fb;
                  mem_wdata <= g_val[DW-1:0];
                  st        <= ST_MEM;
                end
              end
              CLS_ST_REG: begin
                reg_wr    <= 1'b1;
                reg_sel   <= lo_q;
                reg_wdata <= g_val[7:0];
                st        <= fin_st;
                rpt_q     <= fin_rpt;
              end
              CLS_REPEAT: begin
                rpt_q <= g_val[CNTW-1:0];
                st    <= ST_FETCH;
              end
              CLS_KEY: begin
                key_valid <= 1'b1;
                key_value <= g_val;
                st        <= fin_st;
                rpt_q     <= fin_rpt;
              end
              default: st <= ST_FETCH;
            endcase
          end

          ST_MEM: begin
            if (mem_ready) begin
              mem_we <= 1'b0;
              mem_re <= 1'b0;
              if (ptr_post) ptr_q <= ptr_q + AW'(nb);
              if (mem_re) begin
                st <= ST_SEND;
              end else begin
                st    <= fin_st;
                rpt_q <= fin_rpt;
              end
            end
          end

          ST_REG_RD: begin
            reg_rd <= 1'b0;
            st     <= ST_SEND;
          end

          ST_SEND: begin
            if (!e_busy) begin
              st    <= fin_st;
              rpt_q <= fin_rpt;
            end
          end

          default: st <= ST_FETCH;
        endcase
      end
    end
  end

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
  parameter int AW     = 32,
  parameter int DBYTES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 abort_i,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [7:0]           out_data,
  input logic                 mem_we,
  input logic                 mem_re,
  input logic                 mem_ready,
  input logic [AW-1:0]        mem_addr,
  input logic [1:0]           mem_size,
  input logic [8*DBYTES-1:0]  mem_wdata,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic                 key_valid
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid && !mem_we && !mem_re && !reg_wr && !reg_rd && !key_valid));

  p_single_action_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we || mem_re, reg_wr, reg_rd, key_valid}));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (rst || abort_i)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_regwr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  p_key_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  p_abort_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (in_ready && !out_valid && !mem_we && !mem_re));

  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst || abort_i)
    ((mem_we || mem_re) && !mem_ready) |=>
      ((mem_we == $past(mem_we)) && (mem_re == $past(mem_re)) &&
       $stable(mem_addr) && $stable(mem_size) && $stable(mem_wdata)));

  p_req_excl_r14: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

endmodule

bind dbg_seq dbg_seq_chk #(.AW(AW), .DBYTES(DBYTES)) u_chk (.*);

// File: tb/dbg_seq_test.sv
`timescale 1ns/1ps
module dbg_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_i = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_we, mem_re;
  logic [31:0] mem_rdata;
  logic        mem_ready = 1'b0;
  logic [3:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_rdata;
  logic        key_valid;
  logic [63:0] key_value;

  always #10 clk = ~clk;

  dbg_seq uut (
    .clk(clk), .rst(rst), .abort_i(abort_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .key_valid(key_valid), .key_value(key_value)
  );

  // Behavioural memory and register models
  logic [7:0] mem  [256];
  logic [7:0] regs [16];
  logic [7:0] ma, ma1, ma2, ma3;
  assign ma  = mem_addr[7:0];
  assign ma1 = ma + 8'd1;
  assign ma2 = ma + 8'd2;
  assign ma3 = ma + 8'd3;
  assign mem_rdata = {mem[ma3], mem[ma2], mem[ma1], mem[ma]};
  assign reg_rdata = regs[reg_sel];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 8'h35);
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'h40 + i);
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Expectation queues
  logic [7:0]  q_out[$];      string q_out_t[$];
  logic [31:0] q_rd_a[$];     logic [1:0] q_rd_s[$];  string q_rd_t[$];
  logic [31:0] q_wr_a[$];     logic [31:0] q_wr_d[$]; logic [1:0] q_wr_s[$]; string q_wr_t[$];
  logic [3:0]  q_rg_s[$];     logic [7:0] q_rg_d[$];  string q_rg_t[$];
  logic [63:0] q_key[$];      string q_key_t[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_bytes(input logic [31:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q_out.push_back(v[8*i +: 8]);
      q_out_t.push_back(tag);
    end
  endtask

  task automatic exp_read(input logic [31:0] a, input logic [1:0] sz, input string tag);
    q_rd_a.push_back(a); q_rd_s.push_back(sz); q_rd_t.push_back(tag);
    for (int i = 0; i <= int'(sz); i++) begin
      q_out.push_back(mem[8'(a + 32'(i))]);
      q_out_t.push_back(tag);
    end
  endtask

  task automatic exp_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    q_wr_a.push_back(a); q_wr_s.push_back(sz); q_wr_d.push_back(d); q_wr_t.push_back(tag);
  endtask

  // Monitor: every clock, compare observed events with the model
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (q_out.size() == 0) chk("R9 unexpected output byte", {56'd0, out_data}, 64'hFFFF);
        else chk({q_out_t.pop_front(), " output byte"}, {56'd0, out_data}, {56'd0, q_out.pop_front()});
      end
      if (mem_re && mem_ready) begin
        if (q_rd_a.size() == 0) chk("R9 unexpected read", {32'd0, mem_addr}, 64'hFFFF);
        else begin
          chk({q_rd_t[0], " read address"}, {32'd0, mem_addr}, {32'd0, q_rd_a.pop_front()});
          chk({q_rd_t.pop_front(), " read size"}, {62'd0, mem_size}, {62'd0, q_rd_s.pop_front()});
        end
      end
      if (mem_we && mem_ready) begin
        if (q_wr_a.size() == 0) chk("R9 unexpected write", {32'd0, mem_addr}, 64'hFFFF);
        else begin
          chk({q_wr_t[0], " write address"}, {32'd0, mem_addr}, {32'd0, q_wr_a.pop_front()});
          chk({q_wr_t[0], " write size"}, {62'd0, mem_size}, {62'd0, q_wr_s.pop_front()});
          chk({q_wr_t.pop_front(), " write data"}, {32'd0, mem_wdata}, {32'd0, q_wr_d.pop_front()});
        end
        for (int i = 0; i <= int'(mem_size); i++) mem[8'(ma + 8'(i))] = mem_wdata[8*i +: 8];
      end
      if (reg_wr) begin
        if (q_rg_s.size() == 0) chk("R10 unexpected register write", {60'd0, reg_sel}, 64'hFFFF);
        else begin
          chk({q_rg_t[0], " register select"}, {60'd0, reg_sel}, {60'd0, q_rg_s.pop_front()});
          chk({q_rg_t.pop_front(), " register data"}, {56'd0, reg_wdata}, {56'd0, q_rg_d.pop_front()});
        end
        regs[reg_sel] = reg_wdata;
      end
      if (key_valid) begin
        if (q_key.size() == 0) chk("R12 unexpected key", key_value, 64'h0);
        else chk({q_key_t.pop_front(), " key value"}, key_value, q_key.pop_front());
      end
    end
  end

  // Consumer and memory stalls, applied just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready = ($urandom_range(0, 3) != 0);
    mem_ready = ($urandom_range(0, 2) != 0);
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_out.size() != 0 || q_rd_a.size() != 0 || q_wr_a.size() != 0 ||
           q_rg_s.size() != 0 || q_key.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R1 reset quiet", {60'd0, out_valid, mem_we, mem_re, key_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {59'd0, in_ready, out_valid, mem_we, mem_re, reg_wr}, 64'h10);
    chk("R1 pointer reset", 64'd0, 64'd0);
    exp_bytes(32'h0, 4, "R1 R8 pointer after reset");
    put(8'h2B);
    wait_idle();

    // R4 R3: direct load, 1-byte address, 2 data bytes
    exp_read(32'h10, 2'd1, "R4");
    put(8'h01); put(8'h10);
    wait_idle();
    // R3: 2-byte address LSB first, 4 data bytes
    exp_read(32'h1234, 2'd3, "R3 R4");
    put(8'h07); put(8'h34); put(8'h12);
    wait_idle();

    // R5: direct store, 2 address bytes, 3 data bytes
    exp_write(32'h50, 2'd2, 32'h00C3B2A1, "R5");
    put(8'h46); put(8'h50); put(8'h00); put(8'hA1); put(8'hB2); put(8'hC3);
    wait_idle();

    // R6: pointer holds the store address
    exp_bytes(32'h50, 4, "R6");
    put(8'h2B);
    wait_idle();

    // R8: pointer store, then R7 dereference
    put(8'h69); put(8'h80); put(8'h00);
    wait_idle();
    exp_read(32'h80, 2'd0, "R7 R8 deref");
    put(8'h20);
    wait_idle();

    // R7: post-increment load of 2 bytes
    exp_read(32'h80, 2'd1, "R7 postinc load");
    put(8'h25);
    wait_idle();
    exp_bytes(32'h82, 4, "R7 pointer advanced");
    put(8'h2B);
    wait_idle();

    // R7: post-increment store of 1 byte
    exp_write(32'h82, 2'd0, 32'h5A, "R7 postinc store");
    put(8'h64); put(8'h5A);
    wait_idle();

    // R9: reserved pointer mode, load and store, consume nothing
    put(8'h2F);
    put(8'h6C);
    exp_bytes(32'h83, 1, "R9 no-op");
    put(8'h28);
    wait_idle();

    // R10 R2: register store, then load with opcode bit 4 set
    q_rg_s.push_back(4'd5); q_rg_d.push_back(8'h3C); q_rg_t.push_back("R10");
    put(8'hC5); put(8'h3C);
    wait_idle();
    exp_bytes(32'h3C, 1, "R2 R10 readback");
    put(8'h95);
    wait_idle();
    exp_bytes(32'h42, 1, "R10 register 2");
    put(8'h82);
    wait_idle();

    // R11: repeat a post-increment store twice more
    exp_write(32'h83, 2'd0, 32'hD0, "R11 run 1");
    exp_write(32'h84, 2'd0, 32'hD1, "R11 run 2");
    exp_write(32'h85, 2'd0, 32'hD2, "R11 run 3");
    put(8'hA0); put(8'h02);
    put(8'h64); put(8'hD0); put(8'hD1); put(8'hD2);
    wait_idle();
    exp_bytes(32'h86, 1, "R11 repeat ended");
    put(8'h28);
    wait_idle();

    // R11: 2-byte count, direct load resends its address
    exp_read(32'h10, 2'd0, "R11 direct run 1");
    exp_read(32'h11, 2'd0, "R11 direct run 2");
    put(8'hA1); put(8'h01); put(8'h00);
    put(8'h00); put(8'h10); put(8'h11);
    wait_idle();

    // R12: key collection
    q_key.push_back(64'h8877665544332211); q_key_t.push_back("R12");
    put(8'hE0);
    for (int i = 1; i <= 8; i++) put(8'(i * 8'h11));
    wait_idle();

    // R13: abort mid-instruction with a pending repeat count
    put(8'hA0); put(8'h05);
    put(8'h46); put(8'h90);
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk("R13 back to fetch", {63'd0, in_ready}, 64'd1);
    exp_bytes(32'h11, 1, "R13 pointer kept, single run");
    put(8'h28);
    wait_idle();
    exp_read(32'h10, 2'd0, "R13 repeat cleared");
    put(8'h00); put(8'h10);
    wait_idle();

    chk("R3 all expected events seen",
        64'(q_out.size() + q_rd_a.size() + q_wr_a.size() + q_rg_s.size() + q_key.size()), 64'd0);
    finish_run();
  end

endmodule